// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block manages the two sleep states of a small 8-bit microcontroller core. Software asks for a light sleep (CPU clock stopped, peripherals still clocked) or a deep sleep (oscillator stopped) by writing a power-control word. The request is only acted on at the end of the instruction that made it, so the core never stops part-way through an instruction. In light sleep the block releases the CPU clock again as soon as any enabled interrupt is pending. In deep sleep it sleeps until an external interrupt pin is enabled, set to level mode and pulled low. That low level restarts the oscillator. The CPU clock comes back only after a programmable settling count has run out and the pin has returned high.

While asleep the block forces the address-latch and program-fetch strobes to a fixed level: high in light sleep, low in deep sleep. When code runs from external program memory, it also tells the pad logic to float the multiplexed data port in both sleep states, and to keep the address port driven in light sleep only. A power-on flag is set by a dedicated power-up reset and can be written by software. The ordinary hardware reset leaves the flag alone, so software can tell a cold start from a warm start. All pins are plain level control and status signals. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `lpm_ctrl`

## Requirements
- R1: While `por_n` or `rst_n` is low, and after either is released, `mode_o` is 0 (run), `cpu_clk_en`=1, `osc_en`=1, `strobe_hold`=0 and `wake_irq`=0.
- R2: A control write (`ctl_we`) with bit 0 set requests light sleep and bit 1 set requests deep sleep. The request is remembered. The mode changes only at a clock edge where `instr_done`=1, either in the write cycle or later, and becomes visible on `mode_o` (1 = light, 2 = deep) right after that edge.
- R3: If light and deep sleep are both requested, the block enters deep sleep.
- R4: In light sleep `cpu_clk_en`=0 and `osc_en`=1. At the first edge where some `irq_req[i]` and `irq_en[i]` are both 1, the block returns to run, and `wake_irq` is 1 for exactly the first run cycle. A request whose enable bit is 0 has no effect.
- R5: In deep sleep `cpu_clk_en`=0 and `osc_en`=0. General interrupt requests have no effect. An external pin that is low has no effect unless both its `ext_en` and `ext_level` bits are 1.
- R6: A qualified low pin at edge e0 sets `osc_en` to 1 right after e0. With settle count L = `stab_limit`, where the pin stays low up to and including edge eH and is high afterwards, `cpu_clk_en` returns (with the `wake_irq` pulse) after edge e(max(L,H)+1).
- R7: `strobe_hold`=1 in both sleep states, including the oscillator restart phase. `strobe_lvl` is 1 in light sleep and 0 in deep sleep.
- R8: With `ext_prog`=1, `p0_float` is 1 in both sleep states and `p2_addr` is 1 in light sleep only. Both are 0 in run or when `ext_prog`=0.
- R9: `pof` is set to 1 by `por_n` low and takes the value of control bit 2 on every control write. It is unaffected by `rst_n`.
- R10: `rst_n` low returns the block from either sleep state to run immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| por_n | input | 1 | Power-up reset, active low; also sets the power-on flag |
| rst_n | input | 1 | Hardware reset, active low |
| ctl_we | input | 1 | Power-control write strobe |
| ctl_wdata | input | 3 | bit0 light sleep, bit1 deep sleep, bit2 power-on flag value |
| instr_done | input | 1 | Current instruction completes this cycle |
| irq_req | input | NUM_IRQ | Pending interrupt requests |
| irq_en | input | NUM_IRQ | Per-source interrupt enables |
| ext_int_n | input | NUM_EXT | External interrupt pins, active low |
| ext_en | input | NUM_EXT | External interrupt enables |
| ext_level | input | NUM_EXT | 1 = level-sensitive configuration |
| stab_limit | input | CNT_W | Oscillator settle count in cycles |
| ext_prog | input | 1 | Code is fetched from external program memory |
| mode_o | output | 2 | 0 run, 1 light sleep, 2 deep sleep |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| strobe_hold | output | 1 | Override the address-latch and fetch strobes |
| strobe_lvl | output | 1 | Level forced on the strobes while held |
| p0_float | output | 1 | Float the multiplexed data port |
| p2_addr | output | 1 | Keep the address port driving the address |
| wake_irq | output | 1 | One-cycle pulse on an interrupt-caused wake |
| pof | output | 1 | Power-on flag |

## Verification
Two things can fall in the same cycle. In deep sleep, the settle counter can reach its limit in the same cycle that the wake pin returns high. In light sleep, a reset can arrive while an interrupt is waking the block. The bench sweeps the settle limit L from 0 to 4 against pin-low durations H from 0 to 5, so that the pin is released before, at and after the counter expires. For each pair it counts edges from the oscillator restart to the clock release and compares the count with max(L,H)+2, worked out in the bench. The reset cases are driven between clock edges and judged from the ports at once, without waiting for an edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_IDLE    = 2'd1,
    ST_PD_OFF  = 2'd2,
    ST_PD_WARM = 2'd3
  } lpm_state_e;

  localparam int CTL_W        = 3;
  localparam int CTL_IDLE_BIT = 0;
  localparam int CTL_PD_BIT   = 1;
  localparam int CTL_POF_BIT  = 2;

  localparam logic [1:0] MODE_RUN  = 2'd0;
  localparam logic [1:0] MODE_IDLE = 2'd1;
  localparam logic [1:0] MODE_PD   = 2'd2;
endpackage

// File: rtl/lpm_req_latch.sv
module lpm_req_latch
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             clear,
  output logic             want_idle,
  output logic             want_pd
);
  logic pend_idle, pend_pd;
  logic wr_idle, wr_pd;

  assign wr_idle = capture & ctl_we & ctl_wdata[CTL_IDLE_BIT];
  assign wr_pd   = capture & ctl_we & ctl_wdata[CTL_PD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_idle <= 1'b0;
      pend_pd   <= 1'b0;
    end else if (clear) begin
      pend_idle <= 1'b0;
      pend_pd   <= 1'b0;
    end else begin
      pend_idle <= pend_idle | wr_idle;
      pend_pd   <= pend_pd | wr_pd;
    end
  end

  assign want_idle = pend_idle | wr_idle;
  assign want_pd   = pend_pd | wr_pd;
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int NUM_EXT = 2
) (
  input  logic [NUM_EXT-1:0] ext_int_n,
  input  logic [NUM_EXT-1:0] ext_en,
  input  logic [NUM_EXT-1:0] ext_level,
  output logic               wake_lo
);
  logic [NUM_EXT-1:0] hit;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
    assign hit[g] = ~ext_int_n[g] & ext_en[g] & ext_level[g];
  end

  assign wake_lo = |hit;
endmodule

// File: rtl/lpm_stab_cnt.sv
module lpm_stab_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int NUM_EXT = 2,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic               instr_done,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_EXT-1:0] ext_int_n,
  input  logic [NUM_EXT-1:0] ext_en,
  input  logic [NUM_EXT-1:0] ext_level,
  input  logic [CNT_W-1:0]   stab_limit,
  input  logic               ext_prog,
  output logic [1:0]         mode_o,
  output logic               cpu_clk_en,
  output logic               osc_en,
  output logic               strobe_hold,
  output logic               strobe_lvl,
  output logic               p0_float,
  output logic               p2_addr,
  output logic               wake_irq,
  output logic               pof
);
  lpm_state_e state, state_nx;
  logic       sys_rst_n;
  logic       want_idle, want_pd, enter;
  logic       wake_lo, settled, irq_hit, wake_nx;

  assign sys_rst_n = rst_n & por_n;
  assign irq_hit   = |(irq_req & irq_en);
  assign enter     = (state == ST_RUN) & instr_done & (want_idle | want_pd);

  lpm_req_latch u_req (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .capture   (state == ST_RUN),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .clear     (enter),
    .want_idle (want_idle),
    .want_pd   (want_pd)
  );

  lpm_wake_qual #(.NUM_EXT(NUM_EXT)) u_qual (
    .ext_int_n (ext_int_n),
    .ext_en    (ext_en),
    .ext_level (ext_level),
    .wake_lo   (wake_lo)
  );

  lpm_stab_cnt #(.CNT_W(CNT_W)) u_stab (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .clr   (state != ST_PD_WARM),
    .limit (stab_limit),
    .done  (settled)
  );

  always_comb begin
    state_nx = state;
    wake_nx  = 1'b0;
    unique case (state)
      ST_RUN:     if (enter) state_nx = want_pd ? ST_PD_OFF : ST_IDLE;
      ST_IDLE:    if (irq_hit) begin
                    state_nx = ST_RUN;
                    wake_nx  = 1'b1;
                  end
      ST_PD_OFF:  if (wake_lo) state_nx = ST_PD_WARM;
      ST_PD_WARM: if (settled && !wake_lo) begin
                    state_nx = ST_RUN;
                    wake_nx  = 1'b1;
                  end
      default:    state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      state    <= ST_RUN;
      wake_irq <= 1'b0;
    end else begin
      state    <= state_nx;
      wake_irq <= wake_nx;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      pof <= 1'b1;
    else if (ctl_we) pof <= ctl_wdata[CTL_POF_BIT];
  end

  always_comb begin
    unique case (state)
      ST_RUN:  mode_o = MODE_RUN;
      ST_IDLE: mode_o = MODE_IDLE;
      default: mode_o = MODE_PD;
    endcase
  end

  assign cpu_clk_en  = (state == ST_RUN);
  assign osc_en      = (state != ST_PD_OFF);
  assign strobe_hold = (state != ST_RUN);
  assign strobe_lvl  = (state == ST_IDLE);
  assign p0_float    = ext_prog & (state != ST_RUN);
  assign p2_addr     = ext_prog & (state == ST_IDLE);
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int NUM_EXT = 2
) (
  input logic               clk,
  input logic               por_n,
  input logic               rst_n,
  input logic               ctl_we,
  input logic [CTL_W-1:0]   ctl_wdata,
  input logic               instr_done,
  input logic [NUM_EXT-1:0] ext_int_n,
  input logic [NUM_EXT-1:0] ext_en,
  input logic [NUM_EXT-1:0] ext_level,
  input logic [1:0]         mode_o,
  input logic               cpu_clk_en,
  input logic               osc_en,
  input logic               strobe_hold,
  input logic               strobe_lvl,
  input logic               wake_irq,
  input logic               pof
);
  logic ext_wake;
  assign ext_wake = |(~ext_int_n & ext_en & ext_level);

  // R1
  run_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (mode_o == MODE_RUN) |-> (cpu_clk_en && osc_en && !strobe_hold));

  // R3
  both_to_pd_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (mode_o == MODE_RUN && instr_done && ctl_we && ctl_wdata[1:0] == 2'b11)
      |=> (mode_o == MODE_PD));

  // R4
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (mode_o == MODE_IDLE) |-> (!cpu_clk_en && osc_en));

  // R5
  pd_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (mode_o == MODE_PD && !osc_en && !ext_wake) |=> !osc_en);

  // R6
  clk_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    cpu_clk_en |-> osc_en);

  // R4
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wake_irq |-> (cpu_clk_en && $rose(cpu_clk_en)));

  // R7
  strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (mode_o != MODE_RUN) |-> (strobe_hold && (strobe_lvl == (mode_o == MODE_IDLE))));

  // R9
  pof_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !ctl_we |=> $stable(pof));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_EXT(NUM_EXT)) u_lpm_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_n      (rst_n),
  .ctl_we     (ctl_we),
  .ctl_wdata  (ctl_wdata),
  .instr_done (instr_done),
  .ext_int_n  (ext_int_n),
  .ext_en     (ext_en),
  .ext_level  (ext_level),
  .mode_o     (mode_o),
  .cpu_clk_en (cpu_clk_en),
  .osc_en     (osc_en),
  .strobe_hold(strobe_hold),
  .strobe_lvl (strobe_lvl),
  .wake_irq   (wake_irq),
  .pof        (pof)
);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;
  localparam int NI = 4;
  localparam int NE = 2;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          por_n, rst_n, ctl_we, instr_done, ext_prog;
  logic [2:0]    ctl_wdata;
  logic [NI-1:0] irq_req, irq_en;
  logic [NE-1:0] ext_int_n, ext_en, ext_level;
  logic [CW-1:0] stab_limit;
  logic [1:0]    mode_o;
  logic          cpu_clk_en, osc_en, strobe_hold, strobe_lvl;
  logic          p0_float, p2_addr, wake_irq, pof;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;
  logic exp_pof;

  always #2 clk = ~clk;

  lpm_ctrl #(.NUM_IRQ(NI), .NUM_EXT(NE), .CNT_W(CW)) i_lpm_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .instr_done(instr_done), .irq_req(irq_req),
    .irq_en(irq_en), .ext_int_n(ext_int_n), .ext_en(ext_en),
    .ext_level(ext_level), .stab_limit(stab_limit), .ext_prog(ext_prog),
    .mode_o(mode_o), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .strobe_hold(strobe_hold), .strobe_lvl(strobe_lvl), .p0_float(p0_float),
    .p2_addr(p2_addr), .wake_irq(wake_irq), .pof(pof)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [1:0] bits, input logic done);
    ctl_we = 1'b1;
    ctl_wdata = {exp_pof, bits};
    instr_done = done;
    step();
    ctl_we = 1'b0;
    instr_done = 1'b0;
  endtask

  task automatic check_run(input string tag);
    chk({tag, " mode"}, mode_o, 0);
    chk({tag, " cpu_clk_en"}, cpu_clk_en, 1);
    chk({tag, " osc_en"}, osc_en, 1);
    chk({tag, " strobe_hold"}, strobe_hold, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #600000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
    instr_done = 1'b0; irq_req = '0; irq_en = '0; ext_int_n = '1;
    ext_en = '0; ext_level = '0; stab_limit = '0; ext_prog = 1'b0;
    exp_pof = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", mode_o, 0);
    chk("R9 pof on power-up", pof, 1);
    por_n = 1'b1; rst_n = 1'b1;
    step();
    check_run("R1 after reset");
    chk("R1 wake_irq", wake_irq, 0);

    // R9: software write, then warm reset keeps it, power-up sets it
    exp_pof = 1'b0;
    ctl_write(2'b00, 1'b0);
    chk("R9 pof cleared by write", pof, 0);
    rst_n = 1'b0; #1;
    chk("R9 pof kept over rst_n", pof, 0);
    step(); rst_n = 1'b1; step();
    chk("R9 pof after rst_n", pof, 0);
    por_n = 1'b0; #1;
    chk("R9 pof set by por_n", pof, 1);
    exp_pof = 1'b1;
    step(); por_n = 1'b1; step();

    // R2: request held until instruction completes
    ctl_write(2'b01, 1'b0);
    chk("R2 no entry before instr_done", mode_o, 0);
    step();
    chk("R2 still waiting", mode_o, 0);
    instr_done = 1'b1; step(); instr_done = 1'b0;
    chk("R2 entered light sleep", mode_o, 1);
    chk("R4 cpu clock off", cpu_clk_en, 0);
    chk("R4 oscillator on", osc_en, 1);
    chk("R7 strobe hold idle", strobe_hold, 1);
    chk("R7 strobe level idle", strobe_lvl, 1);

    // R4 sweep: every source, enabled or not
    for (int i = 0; i < NI; i++) begin
      for (int e = 0; e < 2; e++) begin
        if (mode_o != 2'd1) ctl_write(2'b01, 1'b1);
        irq_req = NI'(1) << i;
        irq_en  = (e == 1) ? (NI'(1) << i) : ~(NI'(1) << i);
        step();
        if (e == 0) begin
          chk("R4 disabled irq ignored", mode_o, 1);
          chk("R4 no wake pulse", wake_irq, 0);
          irq_en = NI'(1) << i;
          step();
        end
        check_run("R4 idle exit");
        chk("R4 wake pulse", wake_irq, 1);
        irq_req = '0; irq_en = '0;
        step();
        chk("R4 wake pulse one cycle", wake_irq, 0);
      end
    end

    // R3: both requests -> deep sleep
    ctl_write(2'b11, 1'b1);
    chk("R3 both give deep sleep", mode_o, 2);
    chk("R5 oscillator off", osc_en, 0);
    chk("R7 strobe level pd", strobe_lvl, 0);
    // R5: non-qualifying stimuli
    irq_req = '1; irq_en = '1; step();
    chk("R5 general irq ignored", osc_en, 0);
    irq_req = '0; irq_en = '0;
    ext_int_n = 2'b10; ext_en = 2'b01; ext_level = 2'b00; step();
    chk("R5 edge-mode pin ignored", osc_en, 0);
    ext_en = 2'b00; ext_level = 2'b01; step();
    chk("R5 disabled pin ignored", osc_en, 0);
    chk("R5 still deep sleep", mode_o, 2);
    ext_int_n = '1;
    // R10: reset exits deep sleep asynchronously
    rst_n = 1'b0; #1;
    check_run("R10 reset from deep sleep");
    step(); rst_n = 1'b1; step();

    // R10: reset exits light sleep, even with an interrupt arriving
    ctl_write(2'b01, 1'b1);
    irq_req = 4'b0001; irq_en = 4'b0001;
    rst_n = 1'b0; #1;
    check_run("R10 reset from light sleep");
    step(); irq_req = '0; irq_en = '0; rst_n = 1'b1; step();
    chk("R10 no wake pulse after reset", wake_irq, 0);

    // R8: pad hints
    for (int xp = 0; xp < 2; xp++) begin
      ext_prog = xp[0];
      chk("R8 p0 in run", p0_float, 0);
      ctl_write(2'b01, 1'b1);
      chk("R8 p0 float idle", p0_float, xp);
      chk("R8 p2 addr idle", p2_addr, xp);
      irq_req = 4'b0100; irq_en = 4'b0100; step();
      irq_req = '0; irq_en = '0;
      ctl_write(2'b10, 1'b1);
      chk("R8 p0 float pd", p0_float, xp);
      chk("R8 p2 addr pd", p2_addr, 0);
      rst_n = 1'b0; step(); rst_n = 1'b1; step();
    end
    ext_prog = 1'b0;

    // R6 sweep: settle limit against pin-low duration
    for (int L = 0; L <= 4; L++) begin
      for (int H = 0; H <= 5; H++) begin
        int pin;
        int edges;
        int expect_edges;
        pin = (L + H) % 2;
        stab_limit = CW'(L);
        ext_en = NE'(1) << pin; ext_level = NE'(1) << pin;
        ctl_write(2'b10, 1'b1);
        chk("R6 asleep before pin", osc_en, 0);
        ext_int_n = ~(NE'(1) << pin);
        expect_edges = ((L > H) ? L : H) + 2;
        edges = 0;
        while (edges < 20) begin
          step();
          edges++;
          if (edges == 1) begin
            chk("R6 oscillator restarts", osc_en, 1);
            chk("R7 strobe held in restart", strobe_hold, 1);
            chk("R7 strobe low in restart", strobe_lvl, 0);
          end
          if (cpu_clk_en) break;
          if (edges >= H + 1) ext_int_n = '1;
        end
        chk($sformatf("R6 release L=%0d H=%0d", L, H), edges, expect_edges);
        chk("R6 wake pulse", wake_irq, 1);
        ext_int_n = '1; ext_en = '0; ext_level = '0;
        step();
      end
    end

    finish_run();
  end
endmodule